// File: doc/BRIEF.md
# Clocked Synchronous Serial Byte Transmitter

This block sends bytes over a two-wire synchronous link: a serial clock and a data line. Software places a byte in a holding register with a single write. That write also marks the holding register as full by clearing a data-empty flag. On the next cycle, while idle, the transmitter copies the byte into its shift register. It raises the data-empty flag again and starts sending, least significant bit first. The data line changes after each falling edge of the serial clock, and a receiver samples it on the rising edge.

The serial clock comes from one of two sources. In internal mode the block divides the system clock and drives eight pulses per frame on its clock output, which rests high. In external mode it follows a serial clock input, passed through a two-flop synchronizer and edge-detected. The data-empty flag is checked again when the last bit starts. If a new byte is waiting, it is loaded at the end of the frame and sent with no idle gap. If no byte is waiting, a transmit-end flag is set and the data line keeps the level of the last bit. Each flag, ANDed with its own enable input, forms an interrupt request.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset, the data-empty flag is 1, the transmit-end flag is 1, the data line is 1 and the serial clock output is 1.
- R2: A cycle with `wr_en` high stores `wr_data` and clears both flags. Both flags read 0 in the cycle that follows.
- R3: One cycle after the data-empty flag is seen at 0 while idle, the byte is in the shift register, the data-empty flag is back at 1 and the data line carries bit 0 of the byte.
- R4: The bits of a frame appear on `txd` in the order bit 0 through bit 7. Each bit is valid at the rising edge of the serial clock, and `txd` changes only after a falling edge or a load.
- R5: In internal mode each frame has exactly eight serial clock pulses. Each half period lasts `div_half` system clocks, and a value of 0 acts as 1.
- R6: In external mode the block shifts on the edges of `sck_in`, and `sck_out` stays 1.
- R7: If the data-empty flag is 0 when bit 7 starts, the next frame follows with no gap. In internal mode, the first rising edge of the new frame comes 2*`div_half` system clocks after the last rising edge of the old frame.
- R8: If the data-empty flag is 1 when bit 7 starts, the transmit-end flag is set before bit 7 is sampled. After the frame, `txd` holds the bit 7 value and the serial clock rests high.
- R9: `irq_empty` equals the data-empty flag AND `empty_ie`. `irq_end` equals the transmit-end flag AND `end_ie`.
- R10: The transmit-end flag stays 0 throughout a frame when a new byte has been written before bit 7 starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe: stores `wr_data` and clears both flags |
| wr_data | input | 8 | Byte to send |
| ext_clk_mode | input | 1 | 1: follow `sck_in`; 0: generate the serial clock internally |
| div_half | input | 8 | Internal half period in system clocks (0 acts as 1) |
| sck_in | input | 1 | External serial clock |
| empty_ie | input | 1 | Enable for the data-empty request |
| end_ie | input | 1 | Enable for the transmit-end request |
| sck_out | output | 1 | Internally generated serial clock, high at rest |
| txd | output | 1 | Serial data, LSB first |
| empty_flag | output | 1 | Holding register is free for a new byte |
| end_flag | output | 1 | Transmission has ended |
| irq_empty | output | 1 | Data-empty interrupt request |
| irq_end | output | 1 | Transmit-end interrupt request |

## Verification
The assertions rely on three assumptions about the inputs:
- `ext_clk_mode` and `div_half` stay constant while a frame is in progress.
- A write never lands in the same cycle as a load.
- In external mode, `sck_in` rests high and each of its phases lasts several system clocks.

The stimulus changes mode and divider only when the link is idle. It writes the follow-on byte only after the first byte's load has been observed. It drives the external clock with six-cycle phases from the falling system clock edge. A bench receiver samples `txd` on every rising serial clock edge, and the bytes it rebuilds are compared with the bytes written.

// File: rtl/sst_pkg.sv
package sst_pkg;

    localparam int SST_DATA_W = 8;
    localparam int SST_DIV_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_LOADED = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } sck_tick_t;

endpackage

// File: rtl/sst_sckgen.sv
module sst_sckgen
    import sst_pkg::*;
#(
    parameter int DIV_W = SST_DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_mode,
    input  logic [DIV_W-1:0] div_half,
    input  logic             run,
    input  logic             start,
    input  logic             sck_in,
    output sck_tick_t        tick,
    output logic             sck_out
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half_m1;
    logic             sck_int;
    logic             wrap;
    logic             s_meta, s_sync, s_prev;

    assign half_m1 = (div_half == '0) ? '0 : div_half - 1'b1;
    assign wrap    = run && !ext_mode && !start && (cnt == half_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            sck_int <= 1'b1;
        end else if (ext_mode) begin
            cnt     <= '0;
            sck_int <= 1'b1;
        end else if (start) begin
            cnt     <= '0;
            sck_int <= 1'b0;
        end else if (run) begin
            if (cnt == half_m1) begin
                cnt     <= '0;
                sck_int <= ~sck_int;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt     <= '0;
            sck_int <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_meta <= 1'b1;
            s_sync <= 1'b1;
            s_prev <= 1'b1;
        end else begin
            s_meta <= sck_in;
            s_sync <= s_meta;
            s_prev <= s_sync;
        end
    end

    always_comb begin
        if (ext_mode) begin
            tick.rise = s_sync && !s_prev;
            tick.fall = !s_sync && s_prev;
        end else begin
            tick.rise = wrap && !sck_int;
            tick.fall = wrap && sck_int;
        end
    end

    assign sck_out = sck_int;

    assert_tick_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tick.rise, tick.fall}));

    assert_clock_rests_high_R8: assert property (@(posedge clk) disable iff (rst)
        !run |-> sck_out);

endmodule

// File: rtl/sst_regs.sv
module sst_regs
    import sst_pkg::*;
#(
    parameter int DATA_W = SST_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    input  logic              tend_set,
    output logic [DATA_W-1:0] data_reg,
    output logic              empty_flag,
    output logic              tend_flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_reg   <= '0;
            empty_flag <= 1'b1;
            tend_flag  <= 1'b1;
        end else if (wr_en) begin
            data_reg   <= wr_data;
            empty_flag <= 1'b0;
            tend_flag  <= 1'b0;
        end else begin
            if (load)     empty_flag <= 1'b1;
            if (tend_set) tend_flag  <= 1'b1;
        end
    end

    assert_one_load_per_write_R3: assert property (@(posedge clk) disable iff (rst)
        (load && !wr_en) |=> !load);

endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
    import sst_pkg::*;
#(
    parameter int DATA_W = SST_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_mode,
    input  sck_tick_t         tick,
    input  logic              empty_flag,
    input  logic [DATA_W-1:0] data_reg,
    output logic              start,
    output logic              load,
    output logic              tend_set,
    output logic              run,
    output logic              txd
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] PRE_LAST = IDX_W'(DATA_W - 2);

    tx_state_e         state;
    logic [DATA_W-1:0] sr;
    logic [IDX_W-1:0]  idx;
    logic              frame_end;

    assign run       = (state != ST_IDLE);
    assign start     = (state == ST_IDLE) && !empty_flag;
    assign frame_end = (state == ST_SHIFT) && tick.rise && (idx == LAST_IDX);
    assign load      = start || (frame_end && !empty_flag);
    assign tend_set  = (state == ST_SHIFT) && tick.fall && (idx == PRE_LAST) && empty_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            sr    <= '0;
            idx   <= '0;
            txd   <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        sr    <= data_reg;
                        idx   <= '0;
                        txd   <= data_reg[0];
                        state <= ext_mode ? ST_LOADED : ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (frame_end) begin
                        if (!empty_flag) begin
                            sr    <= data_reg;
                            state <= ST_LOADED;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else if (tick.fall && (idx != LAST_IDX)) begin
                        idx <= idx + 1'b1;
                        txd <= sr[idx + 1'b1];
                    end
                end
                ST_LOADED: begin
                    if (tick.fall) begin
                        idx   <= '0;
                        txd   <= sr[0];
                        state <= ST_SHIFT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_txd_steady_R4: assert property (@(posedge clk) disable iff (rst)
        (!tick.fall && !start) |=> $stable(txd));

endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
    import sst_pkg::*;
#(
    parameter int DATA_W = SST_DATA_W,
    parameter int DIV_W  = SST_DIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_clk_mode,
    input  logic [DIV_W-1:0]  div_half,
    input  logic              sck_in,
    input  logic              empty_ie,
    input  logic              end_ie,
    output logic              sck_out,
    output logic              txd,
    output logic              empty_flag,
    output logic              end_flag,
    output logic              irq_empty,
    output logic              irq_end
);

    sck_tick_t         tick;
    logic              start, load, tend_set, run;
    logic [DATA_W-1:0] data_reg;

    sst_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .load       (load),
        .tend_set   (tend_set),
        .data_reg   (data_reg),
        .empty_flag (empty_flag),
        .tend_flag  (end_flag)
    );

    sst_sckgen #(.DIV_W(DIV_W)) u_sckgen (
        .clk      (clk),
        .rst      (rst),
        .ext_mode (ext_clk_mode),
        .div_half (div_half),
        .run      (run),
        .start    (start),
        .sck_in   (sck_in),
        .tick     (tick),
        .sck_out  (sck_out)
    );

    sst_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk        (clk),
        .rst        (rst),
        .ext_mode   (ext_clk_mode),
        .tick       (tick),
        .empty_flag (empty_flag),
        .data_reg   (data_reg),
        .start      (start),
        .load       (load),
        .tend_set   (tend_set),
        .run        (run),
        .txd        (txd)
    );

    assign irq_empty = empty_flag & empty_ie;
    assign irq_end   = end_flag & end_ie;

    assert_end_raised_in_frame_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(end_flag) |-> run);

endmodule

// File: tb/sync_ser_tx_bench.sv
module sync_ser_tx_bench;

    typedef struct packed {
        logic       ext;
        logic [3:0] half;
        logic       b2b;
        logic [7:0] d0;
        logic [7:0] d1;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 4'd1, 1'b0, 8'hA5, 8'h00},
        '{1'b0, 4'd2, 1'b0, 8'h01, 8'h00},
        '{1'b0, 4'd3, 1'b1, 8'h3C, 8'hC3},
        '{1'b1, 4'd0, 1'b0, 8'h80, 8'h00},
        '{1'b1, 4'd0, 1'b1, 8'h5A, 8'hFF},
        '{1'b0, 4'd4, 1'b0, 8'hFE, 8'h00},
        '{1'b0, 4'd0, 1'b1, 8'h12, 8'h34}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ext_mode = 1'b0;
    logic [7:0] div_half = 8'd1;
    logic       sck_drv = 1'b1;
    logic       empty_ie = 1'b0;
    logic       end_ie = 1'b0;
    logic       sck_out, txd, empty_flag, end_flag, irq_empty, irq_end;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int rise_cnt = 0;
    int rise_at [0:15];
    logic [15:0] rx_bits = 16'h0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;

    sync_ser_tx u_sync_ser_tx (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .ext_clk_mode (ext_mode),
        .div_half     (div_half),
        .sck_in       (sck_drv),
        .empty_ie     (empty_ie),
        .end_ie       (end_ie),
        .sck_out      (sck_out),
        .txd          (txd),
        .empty_flag   (empty_flag),
        .end_flag     (end_flag),
        .irq_empty    (irq_empty),
        .irq_end      (irq_end)
    );

    wire line_clk = ext_mode ? sck_drv : sck_out;

    always @(posedge line_clk) begin
        if (!rst) begin
            rx_bits = {txd, rx_bits[15:1]};
            if (rise_cnt < 16) rise_at[rise_cnt] = cyc;
            rise_cnt = rise_cnt + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] d, input bit check_load);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (check_load) begin
            check("R2 empty cleared", int'(empty_flag), 0);
            check("R2 end cleared", int'(end_flag), 0);
            @(negedge clk);
            check("R3 empty set on load", int'(empty_flag), 1);
            check("R3 first bit on line", int'(txd), int'(d[0]));
        end
    endtask

    task automatic ext_pulse();
        sck_drv = 1'b0;
        repeat (6) @(negedge clk);
        sck_drv = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 empty at reset", int'(empty_flag), 1);
        check("R1 end at reset", int'(end_flag), 1);
        check("R1 txd at reset", int'(txd), 1);
        check("R1 sck at reset", int'(sck_out), 1);
        check("R9 irq_empty disabled", int'(irq_empty), 0);
        check("R9 irq_end disabled", int'(irq_end), 0);
        empty_ie = 1'b1;
        end_ie = 1'b1;
        #1;
        check("R9 irq_empty enabled", int'(irq_empty), 1);
        check("R9 irq_end enabled", int'(irq_end), 1);

        for (int v = 0; v < NVEC; v++) begin
            automatic vec_t vc = VECS[v];
            automatic int heff = (vc.half == 0) ? 1 : int'(vc.half);
            automatic int nfr = vc.b2b ? 2 : 1;
            automatic bit mid_done = 1'b0;
            ext_mode = vc.ext;
            div_half = {4'h0, vc.half};
            repeat (4) @(negedge clk);
            rise_cnt = 0;
            rx_bits = 16'h0;
            write_byte(vc.d0, 1'b1);
            if (vc.b2b) begin
                write_byte(vc.d1, 1'b0);
                check("R9 irq_empty follows flag", int'(irq_empty), int'(empty_flag));
            end
            if (vc.ext) begin
                for (int p = 0; p < 8 * nfr; p++) begin
                    ext_pulse();
                    if (p == 7) begin
                        if (vc.b2b) check("R10 end stays low", int'(end_flag), 0);
                        else        check("R8 end before last sample", int'(end_flag), 1);
                    end
                    if (p == 3) check("R6 sck_out quiet", int'(sck_out), 1);
                end
                repeat (8) @(negedge clk);
            end else begin
                for (int w = 0; w < 4000; w++) begin
                    @(negedge clk);
                    if (rise_cnt >= 8 && !mid_done) begin
                        mid_done = 1'b1;
                        if (vc.b2b) check("R10 end stays low", int'(end_flag), 0);
                        else        check("R8 end before last sample", int'(end_flag), 1);
                    end
                    if (rise_cnt >= 8 * nfr) break;
                end
                repeat (4 * heff + 8) @(negedge clk);
                check("R5 period", rise_at[1] - rise_at[0], 2 * heff);
                if (vc.b2b) check("R7 no gap", rise_at[8] - rise_at[7], 2 * heff);
            end
            check(vc.ext ? "R6 pulse count" : "R5 pulse count", rise_cnt, 8 * nfr);
            if (vc.b2b) check("R4 two bytes", int'(rx_bits), int'({vc.d1, vc.d0}));
            else        check("R4 byte order", int'(rx_bits[15:8]), int'(vc.d0));
            check("R8 end flag after frame", int'(end_flag), 1);
            check("R8 txd holds bit 7", int'(txd), int'(vc.b2b ? vc.d1[7] : vc.d0[7]));
            check("R8 sck rests high", int'(sck_out), 1);
            check("R9 irq_end asserted", int'(irq_end), 1);
        end

        ext_mode = 1'b0;
        div_half = 8'd2;
        repeat (4) @(negedge clk);
        write_byte(8'h0F, 1'b0);
        check("R9 irq_end drops on write", int'(irq_end), 0);
        @(negedge clk);
        check("R9 irq_empty after load", int'(irq_empty), 1);
        repeat (60) @(negedge clk);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 txd after second reset", int'(txd), 1);
        check("R1 empty after second reset", int'(empty_flag), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule